// File: doc/BRIEF.md
# SMBus Slave Configuration Register Interface

This block is a slave on a two-wire SMBus. Through it a host reads and writes a small file of 8-bit configuration registers. The block samples the clock and data lines through a synchroniser on the system clock and detects START and STOP. It matches a fixed 7-bit device address and keeps a register pointer. Data bytes are acknowledged by pulling the data line low.

Every register is also driven onto a flat parallel bus, where the surrounding logic reads it. The slave has no drive on the clock line, so it never stretches SCL. It advances only on SCL edges that it observes, so any other device may hold SCL low for as long as it likes.

A register index outside the defined map behaves in a set way:
- A read there returns 00h.
- A write there is acknowledged and then dropped.

Bits marked as reserved in a write mask always hold 0. A START followed directly by a STOP, or a STOP at any point, puts the slave back in its idle state.

Top module: `smb_cfg_slave`

## Requirements
- R1: After a synchronous reset (`rstN` low at a clock edge), register i holds `RESET_IMAGE[8i+7:8i] & WRITE_MASK[8i+7:8i]` on `regBus[8i+7:8i]`, and `sdaPull` is 0. The defaults are 5Ah, 03h, 00h and 41h for registers 0 to 3.
- R2: An address byte whose upper 7 bits equal `SLAVE_ADDR` (default 2Ch; bit 0 is 1 for read and 0 for write) is acknowledged by pulling SDA low during the ninth clock. Any other address gets a NACK. After the NACK, every byte up to the next START is left unacknowledged and changes no register.
- R3: A write takes the form address+W, then an index byte, then data bytes. Each byte is acknowledged. Each data byte goes into the register at the pointer, and the pointer then advances by one.
- R4: Bits that are 0 in `WRITE_MASK` are stored as 0 whatever is written. By default these are bits 7:4 of register 1 and bit 7 of register 3.
- R5: After an index write, a repeated START with address+R returns bytes from successive registers, MSB first. The bytes continue until the master NACKs one, after which the slave leaves SDA released.
- R6: An index at or above `NUM_REGS` reads as 00h. A data byte written to such an index is acknowledged and changes no register.
- R7: A STOP at any point returns the slave to idle, and a data byte cut short by the STOP is not stored. A START followed directly by a STOP leaves the slave ready for the next transaction.
- R8: The slave has no output on SCL and advances only on observed SCL edges. Transfers give the same results while another device holds SCL low for long periods.
- R9: Asserting `rstN` in the middle of a transfer releases SDA and restores every register to its default.
- R10: A repeated START in the middle of a write restarts the address phase. The new transaction's index and data take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sdaPull | output | 1 | When 1, the open-drain pad pulls SDA low |
| regBus | output | 8*NUM_REGS | Register contents; register i at bits 8i+7:8i |

## Verification
The bench builds the block with its default parameters:
- four defined registers, so indices 4 and up are undefined and a multi-byte burst or read can run across the map's end in a few bytes;
- device address 2Ch, with 2Dh serving as the mismatching neighbour;
- a two-stage synchroniser;
- a write mask that reserves the upper nibble of register 1 and the top bit of register 3, so writing FFh exposes both reserved-bit cases.

One pass repeats a write and a read while a second device holds SCL low for 150 cycles before every rising edge.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  // Protocol phases of the slave state machine
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_IDX,
    S_IDX_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } busState_t;

  // Strobes from control to the register datapath
  typedef struct packed {
    logic idxLoad;      // load the pointer from the received byte
    logic dataWrite;    // store the received byte at the pointer, then step it
    logic readAdvance;  // the byte at the pointer has been taken for transmit, step it
  } dpStrobe_t;

endpackage

// File: rtl/smb_cfg_sync.sv
module smb_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic busStart,
  output logic busStop
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclSh;
  logic [LAST:0] sdaSh;
  logic          sclD;
  logic          sdaD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclD  <= 1'b1;
      sdaD  <= 1'b1;
    end else begin
      sclSh <= {sclSh[LAST-1:0], sclIn};
      sdaSh <= {sdaSh[LAST-1:0], sdaIn};
      sclD  <= sclSh[LAST];
      sdaD  <= sdaSh[LAST];
    end
  end

  assign sclLvl   = sclSh[LAST];
  assign sdaLvl   = sdaSh[LAST];
  assign sclRise  = sclLvl & ~sclD;
  assign sclFall  = ~sclLvl & sclD;
  // SDA moving while SCL stays high frames a transaction
  assign busStart = sclLvl & sclD & sdaD & ~sdaLvl;
  assign busStop  = sclLvl & sclD & ~sdaD & sdaLvl;

endmodule

// File: rtl/smb_cfg_ctrl.sv
module smb_cfg_ctrl
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       busStart,
  input  logic       busStop,
  input  logic [7:0] rdByte,
  output dpStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic       sdaPull
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic [7:0] txReg;
  logic       isRead;
  logic       nackSeen;

  logic evFree;
  logic byteDone;
  logic loadTx;

  assign evFree   = !busStart && !busStop;
  assign byteDone = sclFall && (bitCnt == BYTE_BITS) && evFree;
  // end of an ACK clock that hands over a fresh byte to transmit
  assign loadTx   = sclFall && evFree &&
                    ((state == S_ADDR_ACK && isRead) || (state == S_RACK && !nackSeen));

  always_comb begin
    stb.idxLoad     = (state == S_IDX)   && byteDone;
    stb.dataWrite   = (state == S_WDATA) && byteDone;
    stb.readAdvance = loadTx;
  end

  assign rxByte = shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shReg    <= '0;
      txReg    <= '0;
      isRead   <= 1'b0;
      nackSeen <= 1'b0;
      sdaPull  <= 1'b0;
    end else if (busStop) begin
      state   <= S_IDLE;
      sdaPull <= 1'b0;
    end else if (busStart) begin
      state   <= S_ADDR;
      bitCnt  <= '0;
      sdaPull <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR, S_IDX, S_WDATA: begin
          if (sclRise) begin
            shReg  <= {shReg[6:0], sdaLvl};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (state == S_ADDR) begin
              if (shReg[7:1] == SLAVE_ADDR) begin
                isRead  <= shReg[0];
                sdaPull <= 1'b1;
                state   <= S_ADDR_ACK;
              end else begin
                state <= S_IGNORE;
              end
            end else if (state == S_IDX) begin
              sdaPull <= 1'b1;
              state   <= S_IDX_ACK;
            end else begin
              sdaPull <= 1'b1;
              state   <= S_WDATA_ACK;
            end
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              txReg   <= {rdByte[6:0], 1'b0};
              sdaPull <= !rdByte[7];
              state   <= S_RDATA;
            end else begin
              sdaPull <= 1'b0;
              state   <= S_IDX;
            end
          end
        end
        S_IDX_ACK, S_WDATA_ACK: begin
          if (sclFall) begin
            sdaPull <= 1'b0;
            bitCnt  <= '0;
            state   <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == BYTE_BITS) begin
              sdaPull <= 1'b0;
              state   <= S_RACK;
            end else begin
              sdaPull <= !txReg[7];
              txReg   <= {txReg[6:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (sclRise) begin
            nackSeen <= sdaLvl;
          end else if (sclFall) begin
            if (nackSeen) begin
              state <= S_IGNORE;
            end else begin
              bitCnt  <= '0;
              txReg   <= {rdByte[6:0], 1'b0};
              sdaPull <= !rdByte[7];
              state   <= S_RDATA;
            end
          end
        end
        S_IGNORE: begin
          sdaPull <= 1'b0;
        end
        default: begin
          sdaPull <= 1'b0;
        end
      endcase
    end
  end

  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> (state == S_IDLE && !sdaPull)); // R7

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IGNORE) |-> !sdaPull); // R2

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPull) |-> !sclLvl); // R8

  AST_DATA_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataWrite |=> sdaPull); // R3

  AST_RESET_RELEASE: assert property (@(posedge clk)
    !rstN |=> (state == S_IDLE && !sdaPull)); // R9

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int                      NUM_REGS    = 4,
  parameter logic [NUM_REGS*8-1:0]   RESET_IMAGE = 32'h4100_035A,
  parameter logic [NUM_REGS*8-1:0]   WRITE_MASK  = 32'h7FFF_0FFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             stb,
  input  logic [7:0]            rxByte,
  output logic [7:0]            rdByte,
  output logic [NUM_REGS*8-1:0] regBus
);

  localparam int         PTR_W     = 8;
  localparam logic [8:0] REG_LIMIT = 9'(NUM_REGS);

  logic [PTR_W-1:0] ptr;
  logic [7:0]       regArr [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.idxLoad) begin
      ptr <= rxByte;
    end else if (stb.dataWrite || stb.readAdvance) begin
      ptr <= ptr + 8'd1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] KEEP = WRITE_MASK[8*i +: 8];
    localparam logic [7:0] INIT = RESET_IMAGE[8*i +: 8];
    localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regArr[i] <= INIT & KEEP;
      end else if (stb.dataWrite && ptr == MY_IDX) begin
        regArr[i] <= rxByte & KEEP;
      end
    end

    assign regBus[8*i +: 8] = regArr[i];
  end

  // Undefined indices fall through to zero
  always_comb begin
    rdByte = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (ptr == PTR_W'(k)) rdByte = regArr[k];
    end
  end

  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWrite && {1'b0, ptr} >= REG_LIMIT) |=> $stable(regBus)); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataWrite |=> (ptr == $past(ptr) + 8'd1)); // R3

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataWrite |=> ((regBus & ~WRITE_MASK) == '0)); // R4

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]            SLAVE_ADDR  = 7'h2C,
  parameter int                    NUM_REGS    = 4,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_IMAGE = 32'h4100_035A,
  parameter logic [NUM_REGS*8-1:0] WRITE_MASK  = 32'h7FFF_0FFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPull,
  output logic [NUM_REGS*8-1:0] regBus
);

  logic       sclLvl;
  logic       sdaLvl;
  logic       sclRise;
  logic       sclFall;
  logic       busStart;
  logic       busStop;
  dpStrobe_t  stb;
  logic [7:0] rxByte;
  logic [7:0] rdByte;

  smb_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .busStart (busStart),
    .busStop  (busStop)
  );

  smb_cfg_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .busStart (busStart),
    .busStop  (busStop),
    .rdByte   (rdByte),
    .stb      (stb),
    .rxByte   (rxByte),
    .sdaPull  (sdaPull)
  );

  smb_cfg_regs #(
    .NUM_REGS    (NUM_REGS),
    .RESET_IMAGE (RESET_IMAGE),
    .WRITE_MASK  (WRITE_MASK)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rxByte (rxByte),
    .rdByte (rdByte),
    .regBus (regBus)
  );

endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;

  localparam int          HALF    = 20;
  localparam int          STRETCH = 150;
  localparam int          NREG    = 4;
  localparam logic [6:0]  DEV     = 7'h2C;
  localparam logic [31:0] DEF     = 32'h4100_035A;
  localparam logic [31:0] MASK    = 32'h7FFF_0FFF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sclM;
  logic        sdaM;
  logic        stretch;
  logic        stretchOn;
  logic        sdaPull;
  logic [31:0] regBus;

  wire sclLine = sclM & ~stretch;
  wire sdaLine = sdaM & ~sdaPull;

  always #5 clk = ~clk;

  smb_cfg_slave u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclLine),
    .sdaIn   (sdaLine),
    .sdaPull (sdaPull),
    .regBus  (regBus)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] expQ [$];
  logic [7:0] actQ [$];
  string      tagQ [$];

  function automatic logic [31:0] mdlBus();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic mdlReset();
    for (int i = 0; i < NREG; i++) mdl[i] = DEF[8*i +: 8] & MASK[8*i +: 8];
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclHigh();
    if (stretchOn) begin
      stretch = 1'b1;
      sclM = 1'b1;
      waitClk(STRETCH);
      stretch = 1'b0;
    end else begin
      sclM = 1'b1;
    end
  endtask

  task automatic writeBit(input logic b);
    sdaM = b;
    waitClk(HALF);
    sclHigh();
    waitClk(HALF);
    sclM = 1'b0;
    waitClk(4);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1;
    waitClk(HALF);
    sclHigh();
    waitClk(HALF / 2);
    b = sdaLine;
    waitClk(HALF / 2);
    sclM = 1'b0;
    waitClk(4);
  endtask

  task automatic startC();
    sdaM = 1'b1;
    waitClk(4);
    sclHigh();
    waitClk(HALF);
    sdaM = 1'b0;
    waitClk(HALF);
    sclM = 1'b0;
    waitClk(4);
  endtask

  task automatic stopC();
    sdaM = 1'b0;
    waitClk(HALF);
    sclHigh();
    waitClk(HALF);
    sdaM = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(b);
    ack = !b;
  endtask

  task automatic recvByte(output logic [7:0] d, input logic masterAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    writeBit(!masterAck);
  endtask

  // Driver: write burst, model updated from the requirements
  task automatic writeSeq(input logic [7:0] idx, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n, input string req);
    logic ack;
    logic [7:0] data [3];
    int p;
    data[0] = d0; data[1] = d1; data[2] = d2;
    startC();
    sendByte({DEV, 1'b0}, ack);
    check({req, " addr ack"}, 32'(ack), 32'd1);
    sendByte(idx, ack);
    check({req, " index ack"}, 32'(ack), 32'd1);
    p = int'(idx);
    for (int k = 0; k < n; k++) begin
      sendByte(data[k], ack);
      check({req, " data ack"}, 32'(ack), 32'd1);
      if (p < NREG) mdl[p] = data[k] & MASK[8*p +: 8];
      p = (p + 1) % 256;
    end
    stopC();
  endtask

  // Driver: read burst, expected bytes pushed into the scoreboard
  task automatic readSeq(input logic [7:0] idx, input int n, input string req);
    logic ack;
    logic [7:0] d;
    int p;
    startC();
    sendByte({DEV, 1'b0}, ack);
    check({req, " addr ack"}, 32'(ack), 32'd1);
    sendByte(idx, ack);
    check({req, " index ack"}, 32'(ack), 32'd1);
    startC();
    sendByte({DEV, 1'b1}, ack);
    check({req, " read addr ack"}, 32'(ack), 32'd1);
    p = int'(idx);
    for (int k = 0; k < n; k++) begin
      expQ.push_back((p < NREG) ? mdl[p] : 8'h00);
      tagQ.push_back((p < NREG) ? {req, " read byte"} : "R6 undefined read");
      recvByte(d, k < n - 1);
      actQ.push_back(d);
      p = (p + 1) % 256;
    end
    check({req, " SDA released after NACK"}, 32'(sdaLine), 32'd1);
    stopC();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // Monitor: compares read bytes as they arrive
  initial begin
    forever begin
      logic [7:0] a;
      logic [7:0] e;
      string t;
      wait (actQ.size() > 0);
      a = actQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, 32'(a), 32'(e));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic b;
    rstN = 1'b0;
    sclM = 1'b1;
    sdaM = 1'b1;
    stretch = 1'b0;
    stretchOn = 1'b0;
    mdlReset();
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1 reset state
    check("R1 regBus default", regBus, 32'h4100_035A);
    check("R1 SDA released", 32'(sdaPull), 32'd0);

    // R3 / R4 burst write with reserved bits
    writeSeq(8'd0, 8'h11, 8'hFF, 8'h22, 3, "R3");
    check("R3 burst write stored", regBus, mdlBus());
    check("R4 reserved nibble of reg1", 32'(regBus[15:8]), 32'h0F);

    // R5 read across the whole map
    readSeq(8'd0, 4, "R5");

    // R2 wrong address ignored until next START
    startC();
    sendByte({7'h2D, 1'b0}, ack);
    check("R2 mismatched address NACK", 32'(ack), 32'd0);
    sendByte(8'h00, ack);
    check("R2 ignored byte not acked", 32'(ack), 32'd0);
    sendByte(8'h99, ack);
    check("R2 ignored data not acked", 32'(ack), 32'd0);
    stopC();
    check("R2 registers unchanged", regBus, mdlBus());

    // R6 / R4 write running past the map end, then read across it
    writeSeq(8'd3, 8'hFF, 8'hAB, 8'hCD, 3, "R6");
    check("R6 undefined writes dropped", regBus, mdlBus());
    check("R4 reserved bit7 of reg3", 32'(regBus[31:24]), 32'h7F);
    readSeq(8'd2, 4, "R5");

    // R7 STOP in the middle of a data byte
    startC();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'd0, ack);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    stopC();
    check("R7 partial byte not stored", regBus, mdlBus());
    // R7 START directly followed by STOP, then normal use
    startC();
    stopC();
    writeSeq(8'd2, 8'h33, 8'h00, 8'h00, 1, "R7");
    check("R7 write after start-stop", regBus, mdlBus());

    // R10 repeated START inside a write
    startC();
    sendByte({DEV, 1'b0}, ack);
    sendByte(8'd1, ack);
    startC();
    sendByte({DEV, 1'b0}, ack);
    check("R10 address after repeated start", 32'(ack), 32'd1);
    sendByte(8'd2, ack);
    sendByte(8'h5C, ack);
    check("R10 data ack", 32'(ack), 32'd1);
    stopC();
    mdl[2] = 8'h5C;
    check("R10 new index used", regBus, mdlBus());

    // R8 clock held low by another device
    stretchOn = 1'b1;
    writeSeq(8'd0, 8'h77, 8'h00, 8'h00, 1, "R8");
    check("R8 write under stretching", regBus, mdlBus());
    readSeq(8'd0, 2, "R8");
    stretchOn = 1'b0;

    // R9 reset while the slave drives the address ACK
    startC();
    for (int i = 7; i >= 0; i--) writeBit(i == 0 ? 1'b0 : DEV[i-1]);
    sdaM = 1'b1;
    waitClk(HALF);
    check("R2 ACK driven before reset", 32'(sdaLine), 32'd0);
    rstN = 1'b0;
    waitClk(3);
    check("R9 SDA released by reset", 32'(sdaLine), 32'd1);
    mdlReset();
    check("R9 registers back to default", regBus, mdlBus());
    rstN = 1'b1;
    waitClk(4);
    stopC();
    writeSeq(8'd1, 8'hA5, 8'h00, 8'h00, 1, "R9");
    check("R9 usable after reset", regBus, mdlBus());
    readBit(b);

    wait (actQ.size() == 0);
    waitClk(4);
    summary();
    $finish;
  end

endmodule